// File: doc/BRIEF.md
# Embedded Word Boundary Serializer

This block takes parallel words, each announced by a rising edge on a strobe input, and sends them out one bit at a time together with a forwarded bit clock. The receiver finds where a word ends from the forwarded clock itself, so no frame or sync wire is needed. Each word is extended by two boundary bits. During the first of them the low half of the forwarded clock is left out, which keeps the clock high for three half-periods in a row. The two boundary bits also force a data transition while the clock is held high.

The block is clocked at twice the serial bit rate. Each bit period takes two clock cycles: the forwarded clock is high in the first and low in the second, and serial data changes only when a bit period starts. Bit periods that have no word to carry send a zero, with a normal clock pulse and no boundary marker. A word that arrives while another is being sent waits in a one-word holding register and follows directly after the current boundary. Lanes that are unused in a given build are chosen by a parameter mask and are always sent as zero.

Top module: `wbser_top`

## Requirements
- R1: A word is captured only on a rising edge of `strobe`, using the value of `data` at that edge. Holding `strobe` high, or changing `data` while it stays high, starts no further word.
- R2: A word takes 26 bit periods. The first bit sent is `data[0]`, then `data[1]`, and so on up to `data[23]` in the 24th period.
- R3: The 25th bit of a word is the inverse of `data[23]`, and the 26th bit equals `data[23]`.
- R4: In every bit period `ser_clk` is high during the first clock cycle and low during the second. The one exception is the 25th bit of a word, where it also stays high during the second cycle. This gives exactly three high cycles in a row at the boundary, and never more than three.
- R5: A bit period that carries no word has `ser_data` = 0 and a normal high-then-low `ser_clk`.
- R6: A word captured while another word is being sent begins in the bit period right after that word's 26th bit, with no filler period in between.
- R7: If a second strobe edge arrives while the holding register already holds an unsent word, the new word replaces the old one, and the old one is never sent.
- R8: When `enable` is sampled low on a clock edge, `ser_clk` and `ser_data` are 0 from that edge until enable returns. The word being sent and any held word are dropped and are not sent after re-enable.
- R9: While `rst_n` is low, `ser_clk` and `ser_data` are 0.
- R10: A data bit whose position is 0 in the parameter `LANE_MASK` is sent as 0, whatever the input value. The boundary bits are taken from the masked bit 23.
- R11: With the link idle, a word's first bit period starts on the first or second clock edge after the edge that sampled the strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enables the link; low forces both outputs low and drops pending words |
| strobe | input | 1 | Word capture strobe; active on its rising edge |
| data | input | DATA_W | Parallel word; bit 0 is sent first |
| ser_data | output | 1 | Serial data, one bit per two clock cycles |
| ser_clk | output | 1 | Forwarded bit clock carrying the word boundary |

## Verification
A strobe rise sampled at clock edge E0 starts the word's first bit at E1 or E2. The 26th bit therefore starts 50 edges after that, so the bench expects the frame-end detection within the posedge window of 53 to 54 cycles after the strobe was driven. Outputs change only on rising edges; the bench drives inputs and samples outputs on falling edges. Its receiver rebuilds words purely from the rising edges of `ser_clk` and from the three-high boundary run. Words that follow back to back are checked by counting exactly 26 bit starts between frame ends. Disable is checked one falling edge after `enable` drops, and again over the whole disabled window.

// File: rtl/wbser_pkg.sv
package wbser_pkg;
    // What the current bit period carries on the serial line.
    typedef enum logic [1:0] {
        SLOT_FILL = 2'd0,   // no word: zero data, normal clock pulse
        SLOT_DATA = 2'd1,   // payload bit or second boundary bit
        SLOT_MARK = 2'd2    // first boundary bit: low clock half suppressed
    } slot_kind_e;
endpackage

// File: rtl/wbser_capture.sv
module wbser_capture #(
    parameter int unsigned           DATA_W    = 24,
    parameter logic [DATA_W-1:0]     LANE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_word
);
    typedef struct packed {
        logic              strobe_prev;
        logic              valid;
        logic [DATA_W-1:0] word;
    } cap_s;

    cap_s r_q, r_d;
    logic [DATA_W-1:0] masked;
    logic              rise;

    // Lanes that are unused in this build are tied to zero.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (LANE_MASK[i]) begin : g_live
            assign masked[i] = data[i];
        end else begin : g_dead
            assign masked[i] = 1'b0;
        end
    end

    assign rise = strobe & ~r_q.strobe_prev;

    always_comb begin
        r_d             = r_q;
        r_d.strobe_prev = strobe;
        if (!enable) begin
            r_d.valid = 1'b0;
            r_d.word  = '0;
        end else if (rise) begin
            r_d.valid = 1'b1;   // a newer word replaces an unsent one
            r_d.word  = masked;
        end else if (take) begin
            r_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_valid = r_q.valid;
    assign hold_word  = r_q.word;
endmodule

// File: rtl/wbser_framer.sv
module wbser_framer
    import wbser_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_word,
    output logic              take,
    output logic              active,
    output logic              phase,
    output slot_kind_e        kind,
    output logic              bit_val
);
    localparam int unsigned FRAME_LEN = DATA_W + 2;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] MARK_IDX = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic              active;
        logic              phase;   // 0: first half of bit period, 1: second
        slot_kind_e        kind;
        logic [IDX_W-1:0]  idx;     // position inside the 26-bit frame
        logic [DATA_W-1:0] shreg;   // remaining payload, current bit at [0]
        logic              lastb;   // final payload bit, source of boundary bits
        logic              bitv;
    } frm_s;

    frm_s r_q, r_d;
    logic [IDX_W-1:0] idx_nxt;

    assign idx_nxt = r_q.idx + 1'b1;

    always_comb begin
        r_d  = r_q;
        take = 1'b0;
        if (!enable) begin
            r_d = '0;
        end else if (!r_q.active) begin
            r_d.active = 1'b1;          // first period starts as filler, first half
            r_d.phase  = 1'b0;
        end else if (!r_q.phase) begin
            r_d.phase = 1'b1;
        end else begin
            r_d.phase = 1'b0;
            if (r_q.kind != SLOT_FILL && r_q.idx != LAST_IDX) begin
                r_d.idx = idx_nxt;
                if (idx_nxt < MARK_IDX) begin
                    r_d.shreg = r_q.shreg >> 1;
                    r_d.bitv  = r_q.shreg[1];
                    r_d.kind  = SLOT_DATA;
                end else if (idx_nxt == MARK_IDX) begin
                    r_d.bitv = ~r_q.lastb;
                    r_d.kind = SLOT_MARK;
                end else begin
                    r_d.bitv = r_q.lastb;
                    r_d.kind = SLOT_DATA;
                end
            end else if (hold_valid) begin
                take      = 1'b1;
                r_d.idx   = '0;
                r_d.shreg = hold_word;
                r_d.bitv  = hold_word[0];
                r_d.lastb = hold_word[DATA_W-1];
                r_d.kind  = SLOT_DATA;
            end else begin
                r_d.idx   = '0;
                r_d.bitv  = 1'b0;
                r_d.kind  = SLOT_FILL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active  = r_q.active;
    assign phase   = r_q.phase;
    assign kind    = r_q.kind;
    assign bit_val = r_q.bitv;
endmodule

// File: rtl/wbser_drive.sv
module wbser_drive
    import wbser_pkg::*;
(
    input  logic       active,
    input  logic       phase,
    input  slot_kind_e kind,
    input  logic       bit_val,
    output logic       ser_data,
    output logic       ser_clk
);
    always_comb begin
        ser_clk  = active & (~phase | (kind == SLOT_MARK));
        ser_data = active & bit_val;
    end
endmodule

// File: rtl/wbser_top.sv
module wbser_top
    import wbser_pkg::*;
#(
    parameter int unsigned       DATA_W    = 24,
    parameter logic [DATA_W-1:0] LANE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data,
    output logic              ser_data,
    output logic              ser_clk
);
    logic              hold_valid;
    logic [DATA_W-1:0] hold_word;
    logic              take;
    logic              active;
    logic              phase;
    slot_kind_e        kind;
    logic              bit_val;

    wbser_capture #(.DATA_W(DATA_W), .LANE_MASK(LANE_MASK)) u_capture (
        .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .data(data),
        .take(take), .hold_valid(hold_valid), .hold_word(hold_word)
    );

    wbser_framer #(.DATA_W(DATA_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .hold_valid(hold_valid), .hold_word(hold_word), .take(take),
        .active(active), .phase(phase), .kind(kind), .bit_val(bit_val)
    );

    wbser_drive u_drive (
        .active(active), .phase(phase), .kind(kind), .bit_val(bit_val),
        .ser_data(ser_data), .ser_clk(ser_clk)
    );
endmodule

// File: rtl/wbser_chk.sv
module wbser_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ser_data,
    input logic ser_clk
);
    logic [2:0] hi_run_q;   // high samples of ser_clk before the current one

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run_q <= '0;
        else if (ser_clk) hi_run_q <= (hi_run_q == 3'd7) ? 3'd7 : hi_run_q + 3'd1;
        else              hi_run_q <= '0;
    end

    // R4
    max_high_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> hi_run_q <= 3'd2);

    // R4
    single_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !ser_clk) |=> ser_clk);

    // R3
    boundary_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && hi_run_q == 3'd2) |->
            (ser_data != $past(ser_data) && ser_data == $past(ser_data, 3)));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ser_clk && !ser_data));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ser_clk && !ser_data));
endmodule

bind wbser_top wbser_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ser_data(ser_data), .ser_clk(ser_clk)
);

// File: tb/wbser_top_tb_top.sv
`timescale 1ns/1ps
module wbser_top_tb_top;
    localparam int unsigned DW   = 24;
    localparam logic [DW-1:0] MASK = 24'hDFFFFF;   // R10: lane 21 unused

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic strobe = 1'b0;
    logic [DW-1:0] data = '0;
    logic ser_data, ser_clk;

    always #2.5 clk = ~clk;

    wbser_top #(.DATA_W(DW), .LANE_MASK(MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .data(data),
        .ser_data(ser_data), .ser_clk(ser_clk)
    );

    typedef struct { logic [25:0] frame; bit chk_gap; } exp_t;
    exp_t expq[$];

    int n_vec = 0, n_fail = 0, frames_seen = 0, nbits = 0, last_end = 0, run = 0;
    logic prev_clk = 1'b0;
    logic [25:0] hist = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] mk_frame(input logic [DW-1:0] d);
        logic [DW-1:0] m;
        m = d & MASK;
        return {m[DW-1], ~m[DW-1], m};
    endfunction

    // Receiver and scoreboard: bits start at ser_clk rises; third high half is bit 26.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_clk = 1'b0;
            run = 0;
        end else begin
            if (ser_clk) begin
                if (!prev_clk) begin
                    run = 1;
                    hist = {ser_data, hist[25:1]};
                    nbits++;
                end else begin
                    run++;
                    if (run == 3) begin
                        exp_t e;
                        hist = {ser_data, hist[25:1]};
                        nbits++;
                        frames_seen++;
                        if (expq.size() == 0) begin
                            chk(1'b0, "R2 unexpected frame", 32'(hist), 32'h0);
                        end else begin
                            e = expq.pop_front();
                            chk(hist == e.frame, "R2 R3 R10 frame", 32'(hist), 32'(e.frame));
                            if (e.chk_gap)
                                chk(nbits - last_end == 26, "R6 gap", 32'(nbits - last_end), 32'd26);
                        end
                        last_end = nbits;
                    end else if (run > 3) begin
                        chk(1'b0, "R4 high run", 32'(run), 32'd3);
                    end
                end
            end else begin
                run = 0;
            end
            prev_clk = ser_clk;
        end
    end

    task automatic send(input logic [DW-1:0] d, input bit push, input bit gap);
        exp_t e;
        @(negedge clk);
        data = d;
        strobe = 1'b1;
        if (push) begin
            e.frame = mk_frame(d);
            e.chk_gap = gap;
            expq.push_back(e);
        end
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (expq.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        wait_clks(4);
        chk(expq.size() == 0, tag, 32'(expq.size()), 32'd0);
    endtask

    task automatic idle_check(input string tag);
        logic p;
        @(negedge clk);
        p = ser_clk;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(ser_clk != p && ser_data == 1'b0, tag, {30'd0, ser_clk, ser_data}, {30'd0, ~p, 1'b0});
            p = ser_clk;
        end
    endtask

    initial begin
        int f0, cnt;
        // R9: outputs held low in reset even with enable high
        wait_clks(4);
        chk(!ser_clk && !ser_data, "R9 reset outputs", {30'd0, ser_clk, ser_data}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_clks(10);
        f0 = frames_seen;
        idle_check("R5 idle filler");
        chk(frames_seen == f0, "R5 no marker when idle", 32'(frames_seen), 32'(f0));

        // R11 / R2 / R3: single word latency
        f0 = frames_seen;
        @(negedge clk);
        data = 24'h5A3C96;
        strobe = 1'b1;
        begin
            exp_t e;
            e.frame = mk_frame(24'h5A3C96);
            e.chk_gap = 0;
            expq.push_back(e);
        end
        cnt = 0;
        fork
            begin @(negedge clk); strobe = 1'b0; end
        join_none
        while (frames_seen == f0 && cnt < 200) begin
            @(posedge clk);
            cnt++;
        end
        chk(cnt >= 53 && cnt <= 54, "R11 latency", 32'(cnt), 32'd53);
        drain("R2 single word");
        idle_check("R5 filler after word");

        // R1: level-held strobe and moving data give one word only
        f0 = frames_seen;
        @(negedge clk);
        data = 24'h13579B;
        strobe = 1'b1;
        begin
            exp_t e;
            e.frame = mk_frame(24'h13579B);
            e.chk_gap = 0;
            expq.push_back(e);
        end
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            data = data + 24'h010101;
        end
        strobe = 1'b0;
        drain("R1 held strobe");
        wait_clks(60);
        chk(frames_seen == f0 + 1, "R1 one capture", 32'(frames_seen), 32'(f0 + 1));

        // R6: back to back words
        send(24'hC0FFEE, 1, 0);
        wait_clks(6);
        send(24'h3A5A5A, 1, 1);
        drain("R6 back to back");

        // R7: overwrite of the held word
        send(24'h800001, 1, 0);
        wait_clks(6);
        send(24'h111111, 0, 0);
        wait_clks(3);
        send(24'h7EDCBA, 1, 1);
        drain("R7 overwrite");

        // R10: masked lane, both boundary polarities
        send(24'hFFFFFF, 1, 0);
        drain("R10 all ones");
        send(24'h000000, 1, 0);
        drain("R3 all zeros");

        // R8: disable mid-word with a held word pending
        f0 = frames_seen;
        send(24'h2468AC, 0, 0);
        wait_clks(6);
        send(24'h9BDF13, 0, 0);
        wait_clks(10);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!ser_clk && !ser_data, "R8 outputs low", {30'd0, ser_clk, ser_data}, 32'd0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!ser_clk && !ser_data, "R8 stay low", {30'd0, ser_clk, ser_data}, 32'd0);
        end
        enable = 1'b1;
        wait_clks(150);
        chk(frames_seen == f0, "R8 pending dropped", 32'(frames_seen), 32'(f0));
        idle_check("R4 R5 clock after enable");

        send(24'hA5C3E1, 1, 0);
        drain("R2 after re-enable");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule